// File: doc/BRIEF.md
# Fault Classifier and Status Register

This block collects error indications from the parts of a processor core that can detect a fault. These are the instruction fetch path, the load/store path, the memory protection checker, the instruction decoder and the exception stacking engine. In each cycle it sorts every active error into a fault class and picks the handler to request: either the hard-fault handler or the memory-management handler. It also records each error source in its own sticky status bit. The bits are split across two readable status registers.

The memory-management class can be turned off with an enable input. While it is off, a memory-management fault is escalated to a hard fault. The escalation sets a forced-escalation bit and still records the fault's own status bit. Software reads either status register through a small register port and clears bits by writing ones to them. A handler request is a registered one-cycle pulse that follows the cycle in which the error is seen.

Top module: `fault_sorter`

## Requirements
- R1: After reset both status registers read zero and neither `hard_req` nor `mm_req` is high.
- R2: A bus error on a vector table read (`vec_bus_err`) raises `hard_req` in the next cycle and sets hard status bit 0.
- R3: A bus error on fetch sets hard status bit 2. A bus error on a data access sets bit 3. An undefined instruction sets bit 4. Execution with the instruction-set state bit clear sets bit 5. Each of these also raises `hard_req` in the next cycle.
- R4: A protection or memory-map violation on instruction access sets memory status bit 0. Execution from a non-executable region sets the same bit. A violation on a data access sets bit 1.
- R5: A protection violation during exception stacking sets memory status bit 2. A violation during unstacking sets bit 3.
- R6: With `mm_en` high and no hard-class error in the same cycle, a memory-management error raises `mm_req` in the next cycle and does not raise `hard_req`.
- R7: With `mm_en` low, a memory-management error raises `hard_req` and sets hard status bit 1 (forced). It also sets its own memory status bit, and `mm_req` stays low.
- R8: Status bits stay set until software writes a one to them. A write selects the register with `reg_sel` (0 = hard status, 1 = memory status) and clears exactly the bits written as one. Zero bits in the write, and the other register, are left unchanged.
- R9: If a new error sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: If several errors occur in one cycle, all of their status bits are set. At most one request is raised, and hard fault takes priority over memory-management fault.
- R11: `reg_rdata` shows the hard status register when `reg_sel` is 0. It shows the memory status register, zero-extended, when `reg_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mm_en | input | 1 | Enable for the memory-management handler class |
| vec_bus_err | input | 1 | Bus error on a vector table read |
| fetch_bus_err | input | 1 | Bus error on an instruction fetch |
| data_bus_err | input | 1 | Bus error on a data access |
| undef_instr | input | 1 | Undefined instruction decoded |
| state_err | input | 1 | Execution attempted with the instruction-set state bit clear |
| prot_fetch | input | 1 | Protection or memory-map violation on instruction access |
| nx_exec | input | 1 | Execution from a non-executable region |
| prot_data | input | 1 | Protection or memory-map violation on a data access |
| prot_stack | input | 1 | Protection violation during exception stacking |
| prot_unstack | input | 1 | Protection violation during exception unstacking |
| reg_sel | input | 1 | Register select: 0 hard status, 1 memory status |
| reg_wr | input | 1 | Write strobe, write-one-to-clear |
| reg_wdata | input | 6 | Clear mask |
| reg_rdata | output | 6 | Selected status register |
| hard_req | output | 1 | One-cycle hard-fault handler request |
| mm_req | output | 1 | One-cycle memory-management handler request |

## Verification
The assertions assume that every error input and `mm_en` is a clean synchronous level, sampled only at the rising clock edge. They also assume that the write strobe and its mask are stable across that edge. The one-step checks rely on this: a one-cycle error must show up in the status one edge later. The stimulus meets these assumptions by changing every input only on the falling edge and holding it for exactly one full cycle. It drops back to idle after each scored step, so each scoreboard item belongs to exactly one edge.

// File: rtl/fault_pkg.sv
`timescale 1ns/1ps
package fault_pkg;
  localparam int N_HARD = 6;
  localparam int N_MM   = 4;
  localparam int REG_W  = N_HARD;

  localparam int H_VEC   = 0;
  localparam int H_FORCE = 1;
  localparam int H_FBUS  = 2;
  localparam int H_DBUS  = 3;
  localparam int H_UNDEF = 4;
  localparam int H_STATE = 5;

  localparam int M_IACC  = 0;
  localparam int M_DACC  = 1;
  localparam int M_STK   = 2;
  localparam int M_UNSTK = 3;

  function automatic logic [N_MM-1:0] mm_bits(input logic pf, input logic nx,
                                               input logic pd, input logic ps,
                                               input logic pu);
    logic [N_MM-1:0] b;
    b          = '0;
    b[M_IACC]  = pf | nx;
    b[M_DACC]  = pd;
    b[M_STK]   = ps;
    b[M_UNSTK] = pu;
    return b;
  endfunction

  function automatic logic [N_HARD-1:0] hard_bits(input logic vb, input logic fb,
                                                   input logic db, input logic ud,
                                                   input logic st, input logic forced);
    logic [N_HARD-1:0] b;
    b          = '0;
    b[H_VEC]   = vb;
    b[H_FORCE] = forced;
    b[H_FBUS]  = fb;
    b[H_DBUS]  = db;
    b[H_UNDEF] = ud;
    b[H_STATE] = st;
    return b;
  endfunction
endpackage

// File: rtl/fault_decode.sv
`timescale 1ns/1ps
module fault_decode
  import fault_pkg::*;
(
  input  logic              mm_en,
  input  logic              vec_bus_err,
  input  logic              fetch_bus_err,
  input  logic              data_bus_err,
  input  logic              undef_instr,
  input  logic              state_err,
  input  logic              prot_fetch,
  input  logic              nx_exec,
  input  logic              prot_data,
  input  logic              prot_stack,
  input  logic              prot_unstack,
  output logic [N_HARD-1:0] hard_set,
  output logic [N_MM-1:0]   mm_set,
  output logic              take_hard,
  output logic              take_mm
);
  logic mm_any;
  logic direct_hard;
  logic escalate;

  always_comb begin
    mm_set      = mm_bits(prot_fetch, nx_exec, prot_data, prot_stack, prot_unstack);
    mm_any      = |mm_set;
    direct_hard = vec_bus_err | fetch_bus_err | data_bus_err | undef_instr | state_err;
    escalate    = mm_any & ~mm_en;
    hard_set    = hard_bits(vec_bus_err, fetch_bus_err, data_bus_err,
                            undef_instr, state_err, escalate);
    take_hard   = direct_hard | escalate;
    take_mm     = mm_any & mm_en & ~take_hard;
  end
endmodule

// File: rtl/sticky_status.sv
`timescale 1ns/1ps
module sticky_status #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] keep_mask;
  assign keep_mask = clr_en ? ~clr_mask : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & keep_mask) | set_bits;
  end
endmodule

// File: rtl/fault_sorter.sv
`timescale 1ns/1ps
module fault_sorter
  import fault_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mm_en,
  input  logic             vec_bus_err,
  input  logic             fetch_bus_err,
  input  logic             data_bus_err,
  input  logic             undef_instr,
  input  logic             state_err,
  input  logic             prot_fetch,
  input  logic             nx_exec,
  input  logic             prot_data,
  input  logic             prot_stack,
  input  logic             prot_unstack,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             hard_req,
  output logic             mm_req
);
  logic [N_HARD-1:0] hard_set;
  logic [N_MM-1:0]   mm_set;
  logic              take_hard;
  logic              take_mm;
  logic [N_HARD-1:0] hsr_q;
  logic [N_MM-1:0]   msr_q;
  logic              clr_hard;
  logic              clr_mm;

  fault_decode u_dec (
    .mm_en(mm_en), .vec_bus_err(vec_bus_err), .fetch_bus_err(fetch_bus_err),
    .data_bus_err(data_bus_err), .undef_instr(undef_instr), .state_err(state_err),
    .prot_fetch(prot_fetch), .nx_exec(nx_exec), .prot_data(prot_data),
    .prot_stack(prot_stack), .prot_unstack(prot_unstack),
    .hard_set(hard_set), .mm_set(mm_set), .take_hard(take_hard), .take_mm(take_mm)
  );

  assign clr_hard = reg_wr & ~reg_sel;
  assign clr_mm   = reg_wr &  reg_sel;

  sticky_status #(.W(N_HARD)) u_hsr (
    .clk(clk), .rst_n(rst_n), .set_bits(hard_set),
    .clr_en(clr_hard), .clr_mask(reg_wdata[N_HARD-1:0]), .q(hsr_q)
  );

  sticky_status #(.W(N_MM)) u_msr (
    .clk(clk), .rst_n(rst_n), .set_bits(mm_set),
    .clr_en(clr_mm), .clr_mask(reg_wdata[N_MM-1:0]), .q(msr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_req <= 1'b0;
      mm_req   <= 1'b0;
    end else begin
      hard_req <= take_hard;
      mm_req   <= take_mm;
    end
  end

  generate
    if (REG_W > N_MM) begin : g_pad
      assign reg_rdata = reg_sel ? {{(REG_W-N_MM){1'b0}}, msr_q} : hsr_q;
    end else begin : g_nopad
      assign reg_rdata = reg_sel ? msr_q[REG_W-1:0] : hsr_q;
    end
  endgenerate
endmodule

// File: rtl/fault_sorter_chk.sv
`timescale 1ns/1ps
module fault_sorter_chk
  import fault_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mm_en,
  input logic              vec_bus_err,
  input logic              prot_data,
  input logic              prot_stack,
  input logic [N_MM-1:0]   mm_src,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [N_HARD-1:0] hsr,
  input logic [N_MM-1:0]   msr,
  input logic              hard_req,
  input logic              mm_req
);
  // R10
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hard_req, mm_req}));

  // R2
  vec_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_bus_err |=> (hard_req && hsr[H_VEC]));

  // R7
  escalate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mm_src) && !mm_en) |=> (hard_req && !mm_req && hsr[H_FORCE]));

  // R6
  mm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req |-> $past(mm_en && (|mm_src)));

  // R4
  data_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_data |=> msr[M_DACC]);

  // R5
  stack_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_stack |=> msr[M_STK]);

  // R8
  hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(hsr) & ~hsr)) |-> $past(reg_wr && !reg_sel));

  // R8
  mm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(msr) & ~msr)) |-> $past(reg_wr && reg_sel));
endmodule

bind fault_sorter fault_sorter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mm_en(mm_en), .vec_bus_err(vec_bus_err),
  .prot_data(prot_data), .prot_stack(prot_stack), .mm_src(mm_set),
  .reg_sel(reg_sel), .reg_wr(reg_wr), .hsr(hsr_q), .msr(msr_q),
  .hard_req(hard_req), .mm_req(mm_req)
);

// File: tb/sim_fault_sorter.sv
`timescale 1ns/100ps
module sim_fault_sorter;
  // event vector indices used by the bench
  localparam int E_VEC = 0, E_FBUS = 1, E_DBUS = 2, E_UNDEF = 3, E_STATE = 4;
  localparam int E_PF = 5, E_NX = 6, E_PD = 7, E_PS = 8, E_PU = 9;

  typedef struct {
    logic       hard;
    logic       mm;
    logic [5:0] hsr;
    logic [3:0] msr;
    string      tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic mm_en = 0;
  logic [9:0] ev = '0;
  logic reg_sel = 0, reg_wr = 0;
  logic [5:0] reg_wdata = '0;
  logic [5:0] reg_rdata;
  logic hard_req, mm_req;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];
  logic [5:0] m_hsr = '0;
  logic [3:0] m_msr = '0;

  always #2 clk = ~clk;

  fault_sorter u0 (
    .clk(clk), .rst_n(rst_n), .mm_en(mm_en),
    .vec_bus_err(ev[E_VEC]), .fetch_bus_err(ev[E_FBUS]), .data_bus_err(ev[E_DBUS]),
    .undef_instr(ev[E_UNDEF]), .state_err(ev[E_STATE]), .prot_fetch(ev[E_PF]),
    .nx_exec(ev[E_NX]), .prot_data(ev[E_PD]), .prot_stack(ev[E_PS]),
    .prot_unstack(ev[E_PU]), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hard_req(hard_req), .mm_req(mm_req)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic read_both(output logic [5:0] h, output logic [5:0] m);
    logic save;
    save = reg_sel;
    reg_sel = 0; #0.3; h = reg_rdata;
    reg_sel = 1; #0.3; m = reg_rdata;
    reg_sel = save;
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input logic [9:0] e, input logic en, input logic wr,
                      input logic sel, input logic [5:0] wd, input string tag);
    exp_t x;
    logic [5:0] hs;
    logic [3:0] ms;
    logic direct, mmany;
    @(negedge clk);
    ev = e; mm_en = en; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    ms = {e[E_PU], e[E_PS], e[E_PD], e[E_PF] | e[E_NX]};
    mmany = |ms;
    direct = e[E_VEC] | e[E_FBUS] | e[E_DBUS] | e[E_UNDEF] | e[E_STATE];
    hs = {e[E_STATE], e[E_UNDEF], e[E_DBUS], e[E_FBUS], mmany & ~en, e[E_VEC]};
    if (wr && !sel) m_hsr = m_hsr & ~wd;
    if (wr && sel)  m_msr = m_msr & ~wd[3:0];
    m_hsr = m_hsr | hs;
    m_msr = m_msr | ms;
    x.hard = direct | (mmany & ~en);
    x.mm   = mmany & en & ~x.hard;
    x.hsr  = m_hsr;
    x.msr  = m_msr;
    x.tag  = tag;
    sb.push_back(x);
    @(negedge clk);
    ev = '0; reg_wr = 0; reg_wdata = '0;
  endtask

  // monitor: after each rising edge compare against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        logic [5:0] h, m;
        x = sb.pop_front();
        read_both(h, m);
        check(x.tag, "hard_req", hard_req, x.hard);
        check(x.tag, "mm_req", mm_req, x.mm);
        check(x.tag, "hard status (R11 sel0)", h, x.hsr);
        check(x.tag, "mm status (R11 sel1)", m, {2'b00, x.msr});
      end
    end
  end

  task automatic run_tests;
    logic [5:0] h, m;
    repeat (3) @(negedge clk);
    #0.5;
    read_both(h, m);
    check("R1", "hard status", h, 0);
    check("R1", "mm status", m, 0);
    check("R1", "hard_req", hard_req, 0);
    check("R1", "mm_req", mm_req, 0);
    rst_n = 1;

    step(10'b1 << E_VEC,   1, 0, 0, 0, "R2");
    step(10'b1 << E_FBUS,  1, 0, 0, 0, "R3");
    step(10'b1 << E_DBUS,  1, 0, 0, 0, "R3");
    step(10'b1 << E_UNDEF, 1, 0, 0, 0, "R3");
    step(10'b1 << E_STATE, 1, 0, 0, 0, "R3");
    step('0, 1, 1, 0, 6'h3F, "R8");          // clear all hard bits
    step(10'b1 << E_PF,    1, 0, 0, 0, "R4_R6");
    step('0, 1, 1, 1, 6'h01, "R8");
    step(10'b1 << E_NX,    1, 0, 0, 0, "R4");
    step(10'b1 << E_PD,    1, 0, 0, 0, "R4_R6");
    step(10'b1 << E_PS,    1, 0, 0, 0, "R5");
    step(10'b1 << E_PU,    1, 0, 0, 0, "R5");
    step('0, 1, 1, 1, 6'h00, "R8");          // zero mask leaves all bits
    step('0, 1, 1, 0, 6'h3F, "R8");          // other register untouched
    step('0, 1, 1, 1, 6'h05, "R8");          // clears bits 0 and 2 only
    step('0, 1, 1, 1, 6'h0F, "R8");
    step(10'b1 << E_PD,    0, 0, 0, 0, "R7");
    step(10'b1 << E_PU,    0, 0, 0, 0, "R7");
    step('0, 1, 0, 0, 0, "R8_idle");
    step(10'b1 << E_PD,    1, 1, 1, 6'h02, "R9");
    step(10'b1 << E_VEC,   1, 1, 0, 6'h01, "R9");
    step('0, 1, 1, 0, 6'h3F, "R8");
    step('0, 1, 1, 1, 6'h0F, "R8");
    step((10'b1 << E_VEC) | (10'b1 << E_PS), 1, 0, 0, 0, "R10");
    step((10'b1 << E_PF) | (10'b1 << E_PD) | (10'b1 << E_UNDEF), 1, 0, 0, 0, "R10");
    step((10'b1 << E_NX) | (10'b1 << E_PU), 0, 0, 0, 0, "R10_R7");
    step('0, 1, 0, 0, 0, "R6_idle");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule